// File: doc/BRIEF.md
# Write Permit Controller for a Serial Byte Memory

This block sits beside the bus engine of a 4K x 8 serial memory that also carries a separate 32-byte one-time page. It keeps an 8-bit protection configuration register and, for every data byte the engine offers, decides whether that byte may be committed. The byte can be aimed at the main array, the one-time page or the configuration register itself. The block raises a per-byte write enable for the main array or the one-time page, or it updates its own register. If the byte is refused, it raises a refusal flag. The engine must turn that flag into a missing acknowledge for the data byte. Device select and address bytes never pass through this block, so they are acknowledged as normal.

Three mechanisms feed into one decision. A size code in the register makes a low-address slice of the main array permanently read-only. A global protect pin has a level, chosen by a register bit, that blocks all main-array and one-time-page writes. A lock bit makes the register read-only, and a second pin can override that lock. Both pins are brought through synchronisers before they are used. The register is readable at all times.

Top module: `wprot_ctrl`

## Requirements
- R1: After reset the register reads 00h: lock off, protect-pin polarity 0 and size code 000.
- R2: An accepted register write is visible on `cfg_rdata` from the next clock. Bit 7 is the lock, bit 6 is the protect-pin polarity and bits 4:2 are the size code. Bits 5, 1 and 0 always read 0.
- R3: While the lock bit is 0, a register write is always accepted, whatever level the unlock pin has.
- R4: While the lock bit is 1, a register write is accepted only when the synchronised unlock pin is high. When that pin is low, the write is refused with `data_nack` and the register keeps its value.
- R5: Size code c, for c from 1 to 6, makes main addresses below 512·2^(c−1) read-only. Code 000 protects nothing and code 111 protects everything. With 12-bit addresses, codes 100 to 111 therefore cover the whole array.
- R6: A main-array address inside the read-only slice is refused even when the protect pin allows writes.
- R7: When the polarity bit is 0, a high synchronised protect pin blocks writes to the main array and to the one-time page. When the polarity bit is 1, a low pin blocks them.
- R8: Whether a register write is allowed depends only on the lock bit and the unlock pin. It does not depend on the protect pin or on the size code.
- R9: When `byte_req` is low, all three flags are low. When it is high, exactly one of `main_wr_en`, `otp_wr_en` or `data_nack` is high, except for an accepted register write, which raises none of them.
- R10: A change on either pin affects the decision only after SYNC_STAGES rising clock edges. Changes on `byte_req`, `target`, `byte_addr` and the register contents affect the flags in the same cycle.
- R11: Writes to the one-time page ignore the size code.
- R12: Target code 11 is reserved. A byte aimed at it is refused with `data_nack`. Target codes are 00 main array, 01 one-time page and 10 register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_req | input | 1 | A data byte is offered for writing in this cycle |
| target | input | 2 | Destination of the byte: 00 main, 01 one-time page, 10 register, 11 reserved |
| byte_addr | input | ADDR_W | Main-array byte address |
| wdata | input | 8 | Data byte, used when the target is the register |
| wp_pin | input | 1 | Global protect pin; its active level is set by register bit 6 |
| cfg_unlock_pin | input | 1 | Unlock pin; when high it overrides the register lock |
| cfg_rdata | output | 8 | Register readback |
| main_wr_en | output | 1 | Commit the offered byte to the main array |
| otp_wr_en | output | 1 | Commit the offered byte to the one-time page |
| data_nack | output | 1 | Offered byte refused; the engine withholds its acknowledge |

## Verification
The write-permit flags are combinational on the request, target, address and register state, so the bench drives those inputs after a falling edge and compares the flags 1 ns later, within the same cycle. A register write shows on the readback only after the next rising edge, and the bench compares it in the cycle that follows. A pin change reaches the decision after SYNC_STAGES rising edges. The bench reference model keeps its own shift pipeline for each pin and advances it at each edge. Because of this, the cycles just after a pin change are checked against the old pin level, and the later cycles against the new one.

// File: rtl/wprot_pkg.sv
package wprot_pkg;

  localparam int CFG_W = 8;

  typedef enum logic [1:0] {
    TGT_MAIN = 2'b00,
    TGT_OTP  = 2'b01,
    TGT_CFG  = 2'b10,
    TGT_RSVD = 2'b11
  } target_e;

  typedef struct packed {
    logic       lock_en;
    logic       wp_pol;
    logic [2:0] ro_size;
  } cfg_t;

  localparam cfg_t CFG_RESET = '{lock_en: 1'b0, wp_pol: 1'b0, ro_size: 3'b000};

  function automatic logic [CFG_W-1:0] cfg_pack(input cfg_t c);
    return {c.lock_en, c.wp_pol, 1'b0, c.ro_size, 2'b00};
  endfunction

  function automatic cfg_t cfg_unpack(input logic [CFG_W-1:0] d);
    cfg_t c;
    c.lock_en = d[7];
    c.wp_pol  = d[6];
    c.ro_size = d[4:2];
    return c;
  endfunction

endpackage

// File: rtl/wprot_sync.sv
module wprot_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  generate
    if (STAGES == 0) begin : g_bypass
      assign q = d;
    end else begin : g_chain
      logic [STAGES-1:0] chain_q;
      logic [STAGES-1:0] chain_d;

      always_comb begin
        chain_d = {chain_q[STAGES-1:0], d} >> 0;
        chain_d[0] = d;
        for (int i = 1; i < STAGES; i++) begin
          chain_d[i] = chain_q[i-1];
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          chain_q <= '0;
        end else begin
          chain_q <= chain_d;
        end
      end

      assign q = chain_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/wprot_cfg_reg.sv
module wprot_cfg_reg
  import wprot_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_req,
  input  logic [CFG_W-1:0] wdata,
  input  logic             unlock_s,
  output cfg_t             cfg,
  output logic             wr_ok
);

  cfg_t cfg_q;
  cfg_t cfg_d;
  logic cfg_en;

  assign wr_ok  = !cfg_q.lock_en || unlock_s;
  assign cfg_en = wr_req && wr_ok;

  always_comb begin
    cfg_d = cfg_q;
    if (cfg_en) begin
      cfg_d = cfg_unpack(wdata);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= CFG_RESET;
    end else if (cfg_en) begin
      cfg_q <= cfg_d;
    end
  end

  assign cfg = cfg_q;

endmodule

// File: rtl/wprot_ro_map.sv
module wprot_ro_map #(
  parameter int ADDR_W   = 12,
  parameter int BASE_EXP = 9
) (
  input  logic [2:0]        ro_size,
  input  logic [ADDR_W-1:0] addr,
  output logic              ro_hit
);

  logic [7:0] hit_by_code;

  assign hit_by_code[0] = 1'b0;
  assign hit_by_code[7] = 1'b1;

  generate
    for (genvar k = 1; k < 7; k++) begin : g_code
      localparam int EXP = BASE_EXP + k - 1;
      if (EXP >= ADDR_W) begin : g_full
        assign hit_by_code[k] = 1'b1;
      end else begin : g_bound
        assign hit_by_code[k] = (addr[ADDR_W-1:EXP] == '0);
      end
    end
  endgenerate

  assign ro_hit = hit_by_code[ro_size];

endmodule

// File: rtl/wprot_decide.sv
module wprot_decide
  import wprot_pkg::*;
(
  input  logic       byte_req,
  input  logic [1:0] target,
  input  logic       wp_active,
  input  logic       ro_hit,
  input  logic       cfg_ok,
  output logic       main_wr_en,
  output logic       otp_wr_en,
  output logic       cfg_wr,
  output logic       data_nack
);

  always_comb begin
    main_wr_en = 1'b0;
    otp_wr_en  = 1'b0;
    cfg_wr     = 1'b0;
    data_nack  = 1'b0;
    if (byte_req) begin
      unique case (target_e'(target))
        TGT_MAIN: begin
          main_wr_en = !wp_active && !ro_hit;
          data_nack  = wp_active || ro_hit;
        end
        TGT_OTP: begin
          otp_wr_en = !wp_active;
          data_nack = wp_active;
        end
        TGT_CFG: begin
          cfg_wr    = cfg_ok;
          data_nack = !cfg_ok;
        end
        default: begin
          data_nack = 1'b1;
        end
      endcase
    end
  end

endmodule

// File: rtl/wprot_ctrl.sv
module wprot_ctrl
  import wprot_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_req,
  input  logic [1:0]        target,
  input  logic [ADDR_W-1:0] byte_addr,
  input  logic [7:0]        wdata,
  input  logic              wp_pin,
  input  logic              cfg_unlock_pin,
  output logic [7:0]        cfg_rdata,
  output logic              main_wr_en,
  output logic              otp_wr_en,
  output logic              data_nack
);

  logic wp_sync_q;
  logic unlock_sync_q;
  cfg_t cfg;
  logic cfg_ok;
  logic cfg_wr;
  logic ro_hit;
  logic wp_active;

  wprot_sync #(.STAGES(SYNC_STAGES)) i_wp_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (wp_pin),
    .q    (wp_sync_q)
  );

  wprot_sync #(.STAGES(SYNC_STAGES)) i_unlock_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (cfg_unlock_pin),
    .q    (unlock_sync_q)
  );

  wprot_cfg_reg i_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_req  (cfg_wr),
    .wdata   (wdata),
    .unlock_s(unlock_sync_q),
    .cfg     (cfg),
    .wr_ok   (cfg_ok)
  );

  wprot_ro_map #(.ADDR_W(ADDR_W)) i_ro_map (
    .ro_size(cfg.ro_size),
    .addr   (byte_addr),
    .ro_hit (ro_hit)
  );

  assign wp_active = wp_sync_q ^ cfg.wp_pol;

  wprot_decide i_decide (
    .byte_req  (byte_req),
    .target    (target),
    .wp_active (wp_active),
    .ro_hit    (ro_hit),
    .cfg_ok    (cfg_ok),
    .main_wr_en(main_wr_en),
    .otp_wr_en (otp_wr_en),
    .cfg_wr    (cfg_wr),
    .data_nack (data_nack)
  );

  assign cfg_rdata = cfg_pack(cfg);

endmodule

// File: rtl/wprot_ctrl_chk.sv
module wprot_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       byte_req,
  input logic [1:0] target,
  input logic [7:0] wdata,
  input logic [7:0] cfg_rdata,
  input logic       main_wr_en,
  input logic       otp_wr_en,
  input logic       data_nack,
  input logic       wp_s,
  input logic       unlock_s
);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_req |-> !main_wr_en && !otp_wr_en && !data_nack); // R9

  AST_ONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({main_wr_en, otp_wr_en, data_nack})); // R9

  AST_FULL_RO: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata[4:2] == 3'b111) |-> !main_wr_en); // R5

  AST_WP_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (wp_s ^ cfg_rdata[6]) |-> !main_wr_en && !otp_wr_en); // R7

  AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata[7] && !unlock_s) |=> $stable(cfg_rdata)); // R4

  AST_LOCK_NACK: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_req && target == 2'b10 && cfg_rdata[7] && !unlock_s) |-> data_nack); // R4

  AST_OPEN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_req && target == 2'b10 && !cfg_rdata[7]) |=> (cfg_rdata == ($past(wdata) & 8'hDC))); // R3

  AST_RSVD_NACK: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_req && target == 2'b11) |-> data_nack); // R12

endmodule

bind wprot_ctrl wprot_ctrl_chk i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .byte_req  (byte_req),
  .target    (target),
  .wdata     (wdata),
  .cfg_rdata (cfg_rdata),
  .main_wr_en(main_wr_en),
  .otp_wr_en (otp_wr_en),
  .data_nack (data_nack),
  .wp_s      (wp_sync_q),
  .unlock_s  (unlock_sync_q)
);

// File: tb/test_wprot_ctrl.sv
module test_wprot_ctrl;
  localparam int ADDR_W = 12;
  localparam int SYNC   = 2;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              rst_n;
  logic              byte_req;
  logic [1:0]        target;
  logic [ADDR_W-1:0] byte_addr;
  logic [7:0]        wdata;
  logic              wp_pin;
  logic              cfg_unlock_pin;
  logic [7:0]        cfg_rdata;
  logic              main_wr_en;
  logic              otp_wr_en;
  logic              data_nack;

  wprot_ctrl #(.ADDR_W(ADDR_W), .SYNC_STAGES(SYNC)) i_wprot_ctrl (
    .clk(clk), .rst_n(rst_n), .byte_req(byte_req), .target(target),
    .byte_addr(byte_addr), .wdata(wdata), .wp_pin(wp_pin),
    .cfg_unlock_pin(cfg_unlock_pin), .cfg_rdata(cfg_rdata),
    .main_wr_en(main_wr_en), .otp_wr_en(otp_wr_en), .data_nack(data_nack)
  );

  int   checks = 0;
  int   errors = 0;
  bit   done   = 0;
  logic [7:0] m_cfg;
  logic wp_p [SYNC];
  logic un_p [SYNC];
  bit   cur_wp;
  bit   cur_un;

  function automatic bit ro_hit(input logic [2:0] code, input int a);
    if (code == 3'd0) return 1'b0;
    if (code == 3'd7) return 1'b1;
    return a < (256 << code);
  endfunction

  task automatic cyc(input bit req, input logic [1:0] tg, input int a,
                     input logic [7:0] d, input string tag);
    bit wp_act, cfg_ok, em, eo, ec, en;
    byte_req = req; target = tg; byte_addr = a[ADDR_W-1:0]; wdata = d;
    wp_pin = cur_wp; cfg_unlock_pin = cur_un;
    #1;
    wp_act = wp_p[SYNC-1] ^ m_cfg[6];
    cfg_ok = !m_cfg[7] || un_p[SYNC-1];
    em = req && tg == 2'b00 && !wp_act && !ro_hit(m_cfg[4:2], a);
    eo = req && tg == 2'b01 && !wp_act;
    ec = req && tg == 2'b10 && cfg_ok;
    en = req && !(em || eo || ec);
    checks++;
    if ({main_wr_en, otp_wr_en, data_nack, cfg_rdata} !== {em, eo, en, m_cfg}) begin
      errors++;
      $display("FAIL %s: main/otp/nack/cfg actual=%b%b%b/%h expected=%b%b%b/%h (tgt=%0d addr=%h)",
               tag, main_wr_en, otp_wr_en, data_nack, cfg_rdata, em, eo, en, m_cfg, tg, a);
    end
    @(posedge clk);
    if (ec) m_cfg = d & 8'hDC;
    for (int i = SYNC-1; i > 0; i--) begin
      wp_p[i] = wp_p[i-1];
      un_p[i] = un_p[i-1];
    end
    wp_p[0] = cur_wp;
    un_p[0] = cur_un;
    @(negedge clk);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R9: watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; byte_req = 0; target = 0; byte_addr = 0; wdata = 0;
    wp_pin = 0; cfg_unlock_pin = 0; cur_wp = 0; cur_un = 0;
    m_cfg = 8'h00;
    for (int i = 0; i < SYNC; i++) begin wp_p[i] = 0; un_p[i] = 0; end
    void'($urandom(32'h5EED_0017));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    cyc(0, 2'b00, 0, 8'h00, "R1");
    cyc(1, 2'b00, 0, 8'h00, "R1");
    // R2: writable register, reserved bits dropped
    cyc(1, 2'b10, 0, 8'h3F, "R2");
    cyc(0, 2'b00, 0, 8'h00, "R2");
    cyc(1, 2'b00, 12'hFFF, 8'h00, "R6");
    cyc(1, 2'b01, 5, 8'h00, "R11");
    // R3: unlock pin low but lock off
    cyc(1, 2'b10, 0, 8'h00, "R3");
    // R5: sweep size codes at their bounds
    for (int c = 0; c < 8; c++) begin
      cyc(1, 2'b10, 0, 8'(c << 2), "R5");
      cyc(1, 2'b00, 0, 8'h00, "R5");
      cyc(1, 2'b00, (256 << c) - 1 > 4095 ? 4095 : (256 << c) - 1, 8'h00, "R5");
      cyc(1, 2'b00, (256 << c) > 4095 ? 4095 : (256 << c), 8'h00, "R5");
      cyc(1, 2'b01, 31, 8'h00, "R11");
    end
    cyc(1, 2'b10, 0, 8'h04, "R5");
    // R7/R10: protect pin with polarity 0
    cur_wp = 1;
    cyc(1, 2'b00, 12'h800, 8'h00, "R10");
    cyc(1, 2'b00, 12'h800, 8'h00, "R10");
    cyc(1, 2'b00, 12'h800, 8'h00, "R7");
    cyc(1, 2'b01, 3, 8'h00, "R7");
    // R8: register write allowed while protect pin blocks
    cyc(1, 2'b10, 0, 8'h40, "R8");
    cyc(1, 2'b00, 12'h800, 8'h00, "R7");
    cur_wp = 0;
    cyc(1, 2'b01, 3, 8'h00, "R10");
    cyc(1, 2'b01, 3, 8'h00, "R10");
    cyc(1, 2'b01, 3, 8'h00, "R7");
    cyc(1, 2'b00, 12'h100, 8'h00, "R7");
    // R4: lock and override
    cyc(1, 2'b10, 0, 8'h80, "R4");
    cyc(1, 2'b10, 0, 8'h1C, "R4");
    cyc(0, 2'b00, 0, 8'h00, "R4");
    cur_un = 1;
    cyc(1, 2'b10, 0, 8'h1C, "R10");
    cyc(1, 2'b10, 0, 8'h9C, "R4");
    cyc(0, 2'b00, 0, 8'h00, "R4");
    cur_un = 0;
    cyc(0, 2'b00, 0, 8'h00, "R4");
    cyc(0, 2'b00, 0, 8'h00, "R4");
    cyc(1, 2'b10, 0, 8'h00, "R4");
    cyc(1, 2'b11, 0, 8'h00, "R12");
    cyc(0, 2'b11, 0, 8'h00, "R12");

    for (int n = 0; n < 3000; n++) begin
      if ($urandom_range(0, 15) == 0) cur_wp = $urandom_range(0, 1);
      if ($urandom_range(0, 15) == 0) cur_un = $urandom_range(0, 1);
      cyc($urandom_range(0, 3) != 0, 2'($urandom_range(0, 3)),
          int'($urandom_range(0, 4095)), 8'($urandom_range(0, 255)), "R9");
    end

    done = 1;
    summary();
    $finish;
  end
endmodule